// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Loader

This block receives configuration words from an external microcontroller over three wires: a serial clock, a serial data line and a bank-select line. All three are sampled by the block's own system clock through synchronizers. A bit is taken on each rising edge of the serial clock, most significant bit first, into one shift register that both banks share.

The level of the bank-select line decides where a transfer goes. While it is low, the transfer is a 16-bit synthesizer word. Its two lowest bits pick one of four targets: transmit divider, receive divider, control word or reference divider. The word is committed when the line rises, and only if exactly 16 bits arrived. While the line is high, the bits feed a 4-bit oscillator capacitor selection. That selection takes the last four bits received and is committed when the line falls. Each register's contents appear on parallel outputs, which the synthesizer's counters, clock divider and oscillator bank use.

Top module: `pllser_top`

## Requirements
- R1: After reset every output is zero: all dividers, the control word and its fields, the reference option and the capacitor selection.
- R2: A low-bank word is 16 bits sent MSB first; it is word[15:0] in arrival order. Mode bits word[1:0]=00 load tx_div with word[15:2].
- R3: Mode word[1:0]=01 loads rx_div with word[15:2].
- R4: Mode word[1:0]=10 loads ctl_word with word[15:2]. clk_div_sel is ctl_word[1:0], meaning 0 divides by 2, 1 by 3, 2 by 4 and 3 by 5. clk_out_en is ctl_word[2].
- R5: Mode word[1:0]=11 loads ref_div with word[15:4] and ref_opt with word[3:2].
- R6: A committed word changes only the register its mode selects; the other three registers keep their values.
- R7: A low-bank transfer of any length other than 16 bits (15 or 17, for example) changes no output.
- R8: A high-bank transfer loads cap_sel with the last four bits received, with the final bit in the LSB, when ser_en falls. Such a transfer changes no synthesizer register.
- R9: A high-bank transfer of fewer than four bits leaves cap_sel unchanged.
- R10: No output changes while bits are still being shifted. A register updates only after the bank-select edge that ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Bank select; low for synthesizer words, high for capacitor selection |
| tx_div | output | 14 | Transmit channel divider value |
| rx_div | output | 14 | Receive channel divider value |
| ctl_word | output | 14 | Control register contents |
| clk_div_sel | output | 2 | Clock-output divide select (÷2..÷5) |
| clk_out_en | output | 1 | Clock-output enable |
| ref_div | output | 12 | Reference divider value |
| ref_opt | output | 2 | Reference option bits |
| cap_sel | output | 4 | Local oscillator capacitor selection |

## Verification
The bench sweeps all four modes with many computed payloads. In each sweep it checks every output, so a decoder that writes to the wrong register, or to more than one, shows up as a changed neighbour. It sends 15- and 17-bit words, which a loader that ignored the bit count would commit with a shifted payload. It also sends all sixteen capacitor codes with extra leading bits and a three-bit short transfer. A design that took the first four bits, or committed short transfers, would leave the wrong code on cap_sel. Before each ending edge it samples the outputs, so an early commit would be caught too.

// File: rtl/pllser_pkg.sv
package pllser_pkg;
  localparam int WORD_W = 16;
  localparam int MODE_W = 2;
  localparam int OPT_W  = 2;
  localparam int CAP_W  = 4;
  localparam int DATA_W = WORD_W - MODE_W;
  localparam int REF_W  = DATA_W - OPT_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  typedef enum logic [MODE_W-1:0] {
    DST_TX  = 2'b00,
    DST_RX  = 2'b01,
    DST_CTL = 2'b10,
    DST_REF = 2'b11
  } dest_e;
endpackage

// File: rtl/pllser_sync.sv
module pllser_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q, chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int g = 1; g < STAGES; g++) chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pllser_frame.sv
module pllser_frame #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sen_s,
  output logic [WORD_W-1:0] shift_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              end_low,
  output logic              end_high
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);

  logic              sclk_d, sen_d;
  logic              bit_stb, en_edge;
  logic [WORD_W-1:0] shift_n;
  logic [CNT_W-1:0]  cnt_n;

  assign bit_stb  = sclk_s & ~sclk_d;
  assign en_edge  = sen_s ^ sen_d;
  assign end_low  = sen_s & ~sen_d;
  assign end_high = ~sen_s & sen_d;

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    if (bit_stb) shift_n = {shift_q[WORD_W-2:0], sdat_s};
    if (en_edge)
      cnt_n = bit_stb ? CNT_W'(1) : '0;
    else if (bit_stb && cnt_q != CNT_MAX)
      cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sen_d   <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_d  <= sclk_s;
      sen_d   <= sen_s;
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R7
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_s != sen_d) |=> cnt_q <= CNT_W'(1)); // R10
endmodule

// File: rtl/pllser_regs.sv
module pllser_regs
  import pllser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] shift_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              end_low,
  input  logic              end_high,
  output logic [DATA_W-1:0] tx_q,
  output logic [DATA_W-1:0] rx_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic [REF_W-1:0]  ref_q,
  output logic [OPT_W-1:0]  opt_q,
  output logic [CAP_W-1:0]  cap_q
);
  logic              word_ok, cap_ok;
  dest_e             dst;
  logic [DATA_W-1:0] payload;
  logic [DATA_W-1:0] tx_n, rx_n, ctl_n;
  logic [REF_W-1:0]  ref_n;
  logic [OPT_W-1:0]  opt_n;
  logic [CAP_W-1:0]  cap_n;

  assign word_ok = end_low && (cnt_q == CNT_W'(WORD_W));
  assign cap_ok  = end_high && (cnt_q >= CNT_W'(CAP_W));
  assign dst     = dest_e'(shift_q[MODE_W-1:0]);
  assign payload = shift_q[WORD_W-1:MODE_W];

  always_comb begin
    tx_n  = tx_q;
    rx_n  = rx_q;
    ctl_n = ctl_q;
    ref_n = ref_q;
    opt_n = opt_q;
    cap_n = cap_q;
    if (word_ok) begin
      case (dst)
        DST_TX:  tx_n  = payload;
        DST_RX:  rx_n  = payload;
        DST_CTL: ctl_n = payload;
        DST_REF: begin
          ref_n = payload[DATA_W-1:OPT_W];
          opt_n = payload[OPT_W-1:0];
        end
        default: ;
      endcase
    end
    if (cap_ok) cap_n = shift_q[CAP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      ctl_q <= '0;
      ref_q <= '0;
      opt_q <= '0;
      cap_q <= '0;
    end else begin
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      ctl_q <= ctl_n;
      ref_q <= ref_n;
      opt_q <= opt_n;
      cap_q <= cap_n;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(tx_q), !$stable(rx_q), !$stable(ctl_q), !$stable(ref_q)}) <= 1); // R6
  AST_TX_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_q) |-> $past(end_low)); // R10
  AST_REF_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_q) |-> $past(cnt_q) == CNT_W'(WORD_W)); // R7
  AST_CAP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> $past(end_high)); // R8
endmodule

// File: rtl/pllser_top.sv
module pllser_top
  import pllser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en,
  output logic [DATA_W-1:0] tx_div,
  output logic [DATA_W-1:0] rx_div,
  output logic [DATA_W-1:0] ctl_word,
  output logic [1:0]        clk_div_sel,
  output logic              clk_out_en,
  output logic [REF_W-1:0]  ref_div,
  output logic [OPT_W-1:0]  ref_opt,
  output logic [CAP_W-1:0]  cap_sel
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic [2:0]        lines_s;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              end_low, end_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  pllser_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_s),
    .d({ser_en, ser_dat, ser_clk}), .q(lines_s)
  );

  pllser_frame #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_s),
    .sclk_s(lines_s[0]), .sdat_s(lines_s[1]), .sen_s(lines_s[2]),
    .shift_q(shift_q), .cnt_q(cnt_q),
    .end_low(end_low), .end_high(end_high)
  );

  pllser_regs u_regs (
    .clk(clk), .rst_n(rst_s),
    .shift_q(shift_q), .cnt_q(cnt_q),
    .end_low(end_low), .end_high(end_high),
    .tx_q(tx_div), .rx_q(rx_div), .ctl_q(ctl_word),
    .ref_q(ref_div), .opt_q(ref_opt), .cap_q(cap_sel)
  );

  assign clk_div_sel = ctl_word[1:0];
  assign clk_out_en  = ctl_word[2];
endmodule

// File: tb/sim_pllser_top.sv
module sim_pllser_top;
  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_dat, ser_en;
  logic [13:0] tx_div, rx_div, ctl_word;
  logic [1:0]  clk_div_sel, ref_opt;
  logic        clk_out_en;
  logic [11:0] ref_div;
  logic [3:0]  cap_sel;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [13:0] tx_e, rx_e, ctl_e;
  logic [11:0] ref_e;
  logic [1:0]  opt_e;
  logic [3:0]  cap_e;

  always #2.5 clk = ~clk;

  pllser_top u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
    .tx_div(tx_div), .rx_div(rx_div), .ctl_word(ctl_word), .clk_div_sel(clk_div_sel),
    .clk_out_en(clk_out_en), .ref_div(ref_div), .ref_opt(ref_opt), .cap_sel(cap_sel)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
      summary();
    end
  end

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, nm, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "tx_div", tx_div, tx_e);
    chk(req, "rx_div", rx_div, rx_e);
    chk(req, "ctl_word", ctl_word, ctl_e);
    chk(req, "clk_div_sel", clk_div_sel, ctl_e[1:0]);
    chk(req, "clk_out_en", clk_out_en, ctl_e[2]);
    chk(req, "ref_div", ref_div, ref_e);
    chk(req, "ref_opt", ref_opt, opt_e);
    chk(req, "cap_sel", cap_sel, cap_e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bits(logic [31:0] v, int len);
    for (int i = len - 1; i >= 0; i--) begin
      ser_dat = v[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    wait_cyc(4);
  endtask

  // low-bank transfer; only exactly 16 bits commit (R7)
  task automatic synth(logic [31:0] v, int len, string req);
    ser_en = 1'b0;
    wait_cyc(8);
    shift_bits(v, len);
    wait_cyc(8);
    chk_all("R10");
    ser_en = 1'b1;
    if (len == 16) begin
      case (v[1:0])
        2'b00: tx_e  = v[15:2];
        2'b01: rx_e  = v[15:2];
        2'b10: ctl_e = v[15:2];
        default: begin ref_e = v[15:4]; opt_e = v[3:2]; end
      endcase
    end
    wait_cyc(10);
    chk_all(req);
  endtask

  // high-bank transfer; last four bits kept when at least four arrive (R8, R9)
  task automatic capsel(logic [31:0] v, int len, string req);
    ser_en = 1'b1;
    wait_cyc(8);
    shift_bits(v, len);
    wait_cyc(8);
    chk_all("R10");
    ser_en = 1'b0;
    if (len >= 4) cap_e = v[3:0];
    wait_cyc(10);
    chk_all(req);
    ser_en = 1'b1;
    wait_cyc(10);
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_en = 1'b1;
    tx_e = '0; rx_e = '0; ctl_e = '0; ref_e = '0; opt_e = '0; cap_e = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(12);
    chk_all("R1");

    // R2 R3 R4 R5 R6: every mode with computed payloads, all fields checked
    for (int k = 0; k < 8; k++) begin
      for (int m = 0; m < 4; m++) begin
        logic [13:0] d;
        d = 14'((k * 32'h1357 + m * 32'h0A5 + 32'h2A1) & 32'h3FFF);
        case (m)
          0: synth({16'h0, d, 2'b00}, 16, "R2");
          1: synth({16'h0, d, 2'b01}, 16, "R3");
          2: synth({16'h0, d, 2'b10}, 16, "R4");
          default: synth({16'h0, d, 2'b11}, 16, "R5");
        endcase
      end
    end
    // R4: every clock-output divide select with enable on and off
    for (int s = 0; s < 8; s++)
      synth({16'h0, 11'h155, 3'(s), 2'b10}, 16, "R4");
    // R7: wrong lengths discarded in every mode
    for (int m = 0; m < 4; m++) begin
      synth({15'h0, 17'h1FFFC | 17'(m)}, 15, "R7");
      synth({15'h0, 17'h1FFFC | 17'(m)}, 17, "R7");
    end
    // R8: all capacitor codes, with extra leading bits
    for (int c = 0; c < 16; c++)
      capsel({26'h0, 2'(3 - (c % 4)), 4'(c)}, (c % 2 == 0) ? 4 : 6, "R8");
    // R9: short high-bank transfers ignored
    capsel(32'h5, 3, "R9");
    capsel(32'h2, 2, "R9");
    // R6 after mixed traffic
    synth({16'h0, 14'h0001, 2'b01}, 16, "R6");

    done = 1'b1;
    summary();
  end
endmodule